// File: doc/BRIEF.md
# Distributed Row Refresh Controller

This block keeps a dynamic memory's contents valid. It spreads row refresh cycles evenly across the retention period instead of refreshing in bursts. A free-running interval timer raises one refresh request per row slot. The slot length in clocks is the retention period divided by the number of rows and by the clock period. A row counter supplies the row to refresh next. An arbiter places refresh cycles between normal memory accesses.

Each refresh cycle reads one whole row and writes the same data back, because reading a row destroys it. A refresh cycle lasts as long as a normal access cycle. A normal access that is already running is always allowed to finish. A refresh request that arrives during that access is held pending and is served as soon as the access ends. The controller then returns the memory to normal accesses.

The normal-access handshake works like valid/ready. The requester raises `acc_req` and keeps it high until it sees `acc_gnt`. One access starts on the clock edge where both are high. The controller applies back-pressure by holding `acc_gnt` low while any of these is true: an access or refresh cycle is running, a refresh is pending, or reset is asserted.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: The refresh interval is RETENTION_NS / (ROWS * CLK_NS) clocks. With `acc_req` held low after reset is released, `ref_active` first goes high in clock INTERVAL+1.
- R2: A refresh cycle keeps `ref_active` high for exactly CYCLE_CLKS clocks. `row_addr` does not change during it.
- R3: After each completed refresh cycle, `row_addr` increments by one. It wraps from ROWS-1 to 0.
- R4: When the controller is idle and a refresh is pending, the refresh takes priority over `acc_req` and starts on the next clock.
- R5: If the timer expires during a normal access, the refresh is held pending. It starts on the clock after the access ends.
- R6: `acc_gnt` is high only when all of these hold: the controller is idle, no refresh is pending, reset is low and `acc_req` is high. The granted access keeps the controller occupied for CYCLE_CLKS clocks.
- R7: `acc_gnt` stays low throughout a refresh cycle. It can be high again on the clock after the refresh cycle ends.
- R8: `refresh_err` goes high when an interval expires while an earlier refresh is still pending and not starting on that clock. It stays high until reset.
- R9: A synchronous active-high `rst` clears the timer, the row counter, the pending request and the error flag. After reset, `row_addr` is 0 and `busy` and `refresh_err` are low.
- R10: `busy` is high exactly while a normal access cycle or a refresh cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Normal access request (valid-like) |
| acc_gnt | output | 1 | Normal access grant (ready-like); an access starts when both are high |
| ref_active | output | 1 | High while a refresh cycle runs |
| row_addr | output | $clog2(ROWS) | Row being refreshed, or the next row to refresh |
| busy | output | 1 | High while any memory cycle runs |
| refresh_err | output | 1 | Sticky missed-refresh flag |

## Verification
A cycle-accurate reference model is compared with the block's outputs under several request densities, each of which separates a different behaviour:
- `acc_req` held low isolates the timer spacing and the first refresh time.
- `acc_req` held high saturates the arbiter. This shows whether a pending refresh wins over a waiting access, and whether a refresh is deferred until a running access ends.
- Sparse and dense random requests move the timer expiry to every phase of an access cycle.

A second instance uses an interval shorter than one access cycle, which forces missed refreshes and sets the sticky error flag. A reset pulse in the middle of the run checks that the row counter and the error flag are cleared.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_ACCESS  = 2'd1,
    ARB_REFRESH = 2'd2
  } arb_state_t;

  // Clocks per row slot; never below one.
  function automatic int unsigned slot_clocks(int unsigned ret_ns,
                                              int unsigned rows,
                                              int unsigned clk_ns);
    int unsigned v;
    v = ret_ns / (rows * clk_ns);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned INTERVAL = 6250
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (INTERVAL > 1) begin : g_spacing
      // R1: expiries never arrive on consecutive clocks
      p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/refresh_tracker.sv
module refresh_tracker (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_ref,
  output logic pend,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (tick)           pend <= 1'b1;
      else if (start_ref) pend <= 1'b0;
      if (tick && pend && !start_ref) err <= 1'b1;
    end
  end

  // R8: a missed slot raises the flag, and the flag holds
  p_miss_sets_err_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && pend && !start_ref) |=> err);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R4: a refresh start consumes the pending request unless a new one lands
  p_start_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (start_ref && !tick) |=> !pend);
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int unsigned ROWS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_done,
  output logic [$clog2(ROWS)-1:0]  row
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst)           row <= '0;
    else if (ref_done) row <= (row == LAST) ? '0 : row + 1'b1;
  end

  // R3: advance with wrap after a refresh, hold otherwise
  p_row_step_r3: assert property (@(posedge clk) disable iff (rst)
    ref_done |=> (row == (($past(row) == LAST) ? '0 : $past(row) + 1'b1)));
  p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ref_done |=> $stable(row));
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CYCLE_CLKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_req,
  input  logic pend,
  output logic acc_gnt,
  output logic start_ref,
  output logic ref_done,
  output logic ref_active,
  output logic busy
);
  localparam int unsigned CW = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLE_CLKS - 1);

  arb_state_t    st;
  logic [CW-1:0] cnt;
  logic          last;

  always_comb begin
    last      = (cnt == LAST);
    start_ref = !rst && (st == ARB_IDLE) && pend;
    acc_gnt   = !rst && (st == ARB_IDLE) && !pend && acc_req;
    ref_done  = (st == ARB_REFRESH) && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ARB_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: begin
          cnt <= '0;
          if (start_ref)    st <= ARB_REFRESH;
          else if (acc_gnt) st <= ARB_ACCESS;
        end
        default: begin
          if (last) begin
            st  <= ARB_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign ref_active = (st == ARB_REFRESH);
  assign busy       = (st != ARB_IDLE);

  // R7: no grant during refresh
  p_no_gnt_refresh_r7: assert property (@(posedge clk) disable iff (rst)
    ref_active |-> !acc_gnt);
  // R2: a refresh cycle runs its full length
  p_ref_runs_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_active && !last) |=> ref_active);
  // R4: pending refresh in idle starts next clock
  p_pend_first_r4: assert property (@(posedge clk) disable iff (rst)
    ((st == ARB_IDLE) && pend) |=> ref_active);
  // R10: a granted access makes the block busy
  p_gnt_busy_r10: assert property (@(posedge clk) disable iff (rst)
    acc_gnt |=> busy);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int unsigned ROWS         = 64,
  parameter int unsigned RETENTION_NS = 4_000_000,
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned CYCLE_CLKS   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_req,
  output logic                    acc_gnt,
  output logic                    ref_active,
  output logic [$clog2(ROWS)-1:0] row_addr,
  output logic                    busy,
  output logic                    refresh_err
);
  localparam int unsigned INTERVAL = slot_clocks(RETENTION_NS, ROWS, CLK_NS);

  logic tick, pend, start_ref, ref_done;

  refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .tick(tick)
  );

  refresh_tracker u_tracker (
    .clk(clk), .rst(rst), .tick(tick), .start_ref(start_ref),
    .pend(pend), .err(refresh_err)
  );

  refresh_arbiter #(.CYCLE_CLKS(CYCLE_CLKS)) u_arb (
    .clk(clk), .rst(rst), .acc_req(acc_req), .pend(pend),
    .acc_gnt(acc_gnt), .start_ref(start_ref), .ref_done(ref_done),
    .ref_active(ref_active), .busy(busy)
  );

  refresh_row_counter #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst(rst), .ref_done(ref_done), .row(row_addr)
  );

  // R10: refresh implies busy
  p_ref_busy_r10: assert property (@(posedge clk) disable iff (rst)
    ref_active |-> busy);
endmodule

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;
  localparam int ROWS_A = 8,  RET_A = 3200, CLKNS = 10, CYC_A = 4; // interval 40
  localparam int ROWS_B = 4,  RET_B = 120,  CYC_B = 6;             // interval 3
  localparam int IV_A = RET_A / (ROWS_A * CLKNS);
  localparam int IV_B = RET_B / (ROWS_B * CLKNS);
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_a = 1'b0, req_b = 1'b0;
  logic gnt_a, ref_a, busy_a, err_a, gnt_b, ref_b, busy_b, err_b;
  logic [$clog2(ROWS_A)-1:0] row_a;
  logic [$clog2(ROWS_B)-1:0] row_b;

  always #5 clk = ~clk;

  dram_refresh_ctrl #(.ROWS(ROWS_A), .RETENTION_NS(RET_A), .CLK_NS(CLKNS),
                      .CYCLE_CLKS(CYC_A)) dut (
    .clk(clk), .rst(rst), .acc_req(req_a), .acc_gnt(gnt_a),
    .ref_active(ref_a), .row_addr(row_a), .busy(busy_a), .refresh_err(err_a));

  dram_refresh_ctrl #(.ROWS(ROWS_B), .RETENTION_NS(RET_B), .CLK_NS(CLKNS),
                      .CYCLE_CLKS(CYC_B)) dut_err (
    .clk(clk), .rst(rst), .acc_req(req_b), .acc_gnt(gnt_b),
    .ref_active(ref_b), .row_addr(row_b), .busy(busy_b), .refresh_err(err_b));

  // Reference model, state: 0 idle, 1 access, 2 refresh
  typedef struct {int st; int cnt; int tmr; int row; int pend; int err;} mdl_t;

  function automatic mdl_t m_reset();
    mdl_t m;
    m.st = 0; m.cnt = 0; m.tmr = 0; m.row = 0; m.pend = 0; m.err = 0;
    return m;
  endfunction

  function automatic int m_gnt(mdl_t m, bit req, bit r);
    return (!r && m.st == 0 && m.pend == 0 && req) ? 1 : 0;
  endfunction

  function automatic mdl_t m_step(mdl_t m, bit req, bit r, int iv, int cyc, int rows);
    mdl_t n;
    int tick, sref, gnt;
    if (r) return m_reset();
    n = m;
    tick = (m.tmr == iv - 1);
    n.tmr = tick ? 0 : m.tmr + 1;
    sref = (m.st == 0 && m.pend != 0);
    gnt = m_gnt(m, req, r);
    if (tick) begin
      if (m.pend != 0 && !sref) n.err = 1;
      n.pend = 1;
    end else if (sref) n.pend = 0;
    if (m.st == 2 && m.cnt == cyc - 1) n.row = (m.row == rows - 1) ? 0 : m.row + 1;
    if (m.st == 0) begin
      n.cnt = 0;
      if (sref) n.st = 2; else if (gnt) n.st = 1;
    end else if (m.cnt == cyc - 1) begin
      n.st = 0; n.cnt = 0;
    end else n.cnt = m.cnt + 1;
    return n;
  endfunction

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(mdl_t ma, mdl_t mb);
    int eg;
    eg = m_gnt(ma, req_a, rst);
    chk(gnt_a == eg, "R6 R7 grant", gnt_a, eg);
    chk(ref_a == (ma.st == 2), "R2 R4 R5 ref_active", ref_a, ma.st == 2);
    chk(busy_a == (ma.st != 0), "R10 busy", busy_a, ma.st != 0);
    chk(row_a == ma.row, "R3 row_addr", row_a, ma.row);
    chk(err_a == ma.err, "R8 err", err_a, ma.err);
    eg = m_gnt(mb, req_b, rst);
    chk(gnt_b == eg, "R6 R7 grant short-interval", gnt_b, eg);
    chk(ref_b == (mb.st == 2), "R2 R5 ref_active short-interval", ref_b, mb.st == 2);
    chk(row_b == mb.row, "R3 row_addr short-interval", row_b, mb.row);
    chk(err_b == mb.err, "R8 err short-interval", err_b, mb.err);
  endtask

  initial begin
    mdl_t ma, mb;
    int first_ref;
    bit seen_err;
    void'($urandom(32'd1234));
    ma = m_reset(); mb = m_reset();
    first_ref = -1; seen_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(row_a == 0 && !busy_a && !err_a, "R9 reset state", row_a, 0);
    rst = 1'b0;
    for (int i = 1; i <= NCYC; i++) begin
      @(posedge clk); #1;
      ma = m_step(ma, req_a, rst, IV_A, CYC_A, ROWS_A);
      mb = m_step(mb, req_b, rst, IV_B, CYC_B, ROWS_B);
      @(negedge clk);
      cmp_all(ma, mb);
      if (first_ref < 0 && ref_a) begin
        first_ref = i;
        chk(i == IV_A + 1, "R1 first refresh clock", i, IV_A + 1);
      end
      if (err_b) seen_err = 1;
      if (i == 2003) begin
        chk(row_a == 0 && row_b == 0, "R9 row cleared", row_a + row_b, 0);
        chk(!err_b && !busy_a, "R9 err/busy cleared", err_b, 0);
      end
      // drive next inputs
      rst = (i >= 2000 && i < 2003);
      if (i < 200)       req_a = 1'b0;
      else if (i < 1000) req_a = 1'b1;
      else if (i < 2000) req_a = ($urandom % 2) == 0;
      else if (i < 3000) req_a = ($urandom % 4) == 0;
      else               req_a = ($urandom % 10) != 0;
      req_b = ($urandom % 2) == 0;
    end
    chk(seen_err, "R8 error reached", seen_err, 1);
    chk(first_ref == IV_A + 1, "R1 refresh seen", first_ref, IV_A + 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (NCYC + 2000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule